// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every reset request of the chip into one chip-wide reset output. The sources are a power-on detector, a brown-out detector, an external reset pin with its own enable, a watchdog time-out, a software reset strobe, and stack overflow and stack underflow strobes. Once any request arrives, the chip reset is asserted and held. It is released only when no request is still active and the staged start-up delay has finished. The delay has two stages. A power-up timer counts on the low-frequency internal clock. An oscillator start-up timer then counts on the external oscillator clock. Only power-on and brown-out clear these timers, so resets from any other source release almost at once.

The block records the source of the most recent reset as a one-hot cause vector. It also keeps two status bits, time-out and power-down, which firmware reads to tell the cause apart. If the watchdog expires while the core is asleep, the block produces a one-cycle wake pulse and does not reset the chip.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status level. Power-on detect is the asynchronous reset of the whole block. The software, stack, watchdog, sleep and timer-enable inputs are synchronous to `clk_lf`. Brown-out and the external pin are asynchronous, and each passes through two-flop synchronizers.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_det` is high, and after it falls until the sequence ends, `chip_rst` is 1, `to_bit` and `pd_bit` are 1, and `cause` is 7'b0000001. Cause bit positions are: 0 power-on, 1 brown-out, 2 external pin, 3 watchdog, 4 software, 5 stack overflow, 6 stack underflow.
- R2: With `pwrt_en` high, `chip_rst` stays 1 for at least 2^PWRT_W (2048) `clk_lf` cycles after a power-on or brown-out request ends.
- R3: With `ost_en` high, the start-up timer counts 2^OST_W (1024) `clk_osc` cycles, and it starts only after the power-up stage has completed. `chip_rst` cannot fall before the start-up timer is done.
- R4: A stage whose enable is low counts as complete at once. With both enables low, `chip_rst` falls within 10 `clk_lf` cycles after a brown-out ends.
- R5: The external pin (active low) is seen as a request only when `mclr_en` is 1 and the synchronized pin has been low for FILT_LEN (4) consecutive `clk_lf` samples. Shorter pulses are ignored. The request lasts as long as the pin stays low, and `chip_rst` stays 1 for that whole time.
- R6: A one-cycle `sw_rst`, `stk_ovf` or `stk_unf` strobe, given while both timers are complete, sets `chip_rst` for exactly one cycle starting at the next edge.
- R7: `wdt_to` with `sleep_i` low is a reset request. It records cause bit 3, clears `to_bit` and leaves `pd_bit` unchanged.
- R8: `wdt_to` with `sleep_i` high gives a one-cycle `wake` pulse on the next edge. It does not assert `chip_rst`, it clears both `to_bit` and `pd_bit`, and it leaves `cause` unchanged.
- R9: An external-pin reset taken while `sleep_i` is high clears `pd_bit` and leaves `to_bit` unchanged. Brown-out, software, stack and awake external resets leave both status bits unchanged.
- R10: `cause` is always one-hot. If several requests begin in the same cycle, the priority is brown-out, then external pin, then watchdog, then software, then overflow, then underflow.
- R11: `chip_rst` stays 1 while `bor_det` is high, and a brown-out clears both timers so that the full enabled delay runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Low-frequency internal clock; control domain and power-up timer clock |
| clk_osc | input | 1 | External oscillator clock for the start-up timer |
| por_det | input | 1 | Power-on detect, active high, asynchronous |
| bor_det | input | 1 | Brown-out detect, active high, asynchronous |
| mclr_n | input | 1 | External reset pin, active low, asynchronous |
| mclr_en | input | 1 | Enable for the external reset pin |
| wdt_to | input | 1 | Watchdog time-out strobe |
| sleep_i | input | 1 | Core is in sleep |
| sw_rst | input | 1 | Software reset strobe |
| stk_ovf | input | 1 | Stack overflow strobe |
| stk_unf | input | 1 | Stack underflow strobe |
| pwrt_en | input | 1 | Enable for the power-up timer stage |
| ost_en | input | 1 | Enable for the oscillator start-up stage |
| chip_rst | output | 1 | Chip-wide reset, active high |
| wake | output | 1 | One-cycle wake-up pulse from a watchdog expiry during sleep |
| to_bit | output | 1 | Time-out status bit |
| pd_bit | output | 1 | Power-down status bit |
| cause | output | 7 | One-hot cause of the most recent reset |

## Verification
A corrupted timer count or a stale completion flag shows up as a `chip_rst` release that comes too early or too late. That error is measured against the 2048-cycle and 1024-cycle windows only after the whole delay has run, so it appears thousands of cycles after the brown-out or power-on. A wrong priority, a wrong filter length or a wrong status-update rule shows up within a few cycles. It is visible as the wrong `cause` bit, a spurious or missing `chip_rst` pulse, or wrong `to_bit`/`pd_bit` values, read at the moment the reset falls or the wake pulse appears. A stale start-up flag that crosses back between the clock domains is caught only by the brown-out case where the power-up timer is disabled, because there the start-up stage alone bounds the release.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int NCAUSE = 7;
  localparam int C_POR  = 0;
  localparam int C_BOR  = 1;
  localparam int C_EXT  = 2;
  localparam int C_WDT  = 3;
  localparam int C_SW   = 4;
  localparam int C_OVF  = 5;
  localparam int C_UNF  = 6;
  typedef logic [NCAUSE-1:0] cause_t;
endpackage

// File: rtl/rst_sync.sv
// Reset synchronizer: asynchronous assertion, two-flop synchronous release.
module rst_sync (
  input  logic clk,
  input  logic arst,
  output logic rst_n
);
  logic [1:0] stg;
  always_ff @(posedge clk or posedge arst) begin
    if (arst) stg <= 2'b00;
    else      stg <= {stg[0], 1'b1};
  end
  assign rst_n = stg[1];
endmodule

// File: rtl/bit_sync.sv
// Two-flop synchronizer for a vector of independent levels.
module bit_sync #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= INIT[i];
        s2 <= INIT[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/pin_filter.sv
// Counts consecutive low samples; the request holds while the pin stays low.
module pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pin_low_i,
  output logic active_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_LEN);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run_cnt <= '0;
    else if (!en_i || !pin_low_i)  run_cnt <= '0;
    else if (run_cnt != LIM)       run_cnt <= run_cnt + 1'b1;
  end

  assign active_o = (run_cnt == LIM);

  p_filter_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (pin_low_i && en_i) || $past(pin_low_i && en_i));
  p_filter_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !active_o);
endmodule

// File: rtl/seq_timer.sv
// Delay stage: after start, finishes after 2**CNT_W cycles of its clock.
module seq_timer #(
  parameter int CNT_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (start_i && !done_q) begin
      if (cnt == LAST) done_q <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end

  assign done_o = done_q;

  p_done_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clr_i) |=> done_o);
  p_clear_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !done_o);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int PWRT_W   = 11,
  parameter int OST_W    = 10,
  parameter int FILT_LEN = 4
) (
  input  logic              clk_lf,
  input  logic              clk_osc,
  input  logic              por_det,
  input  logic              bor_det,
  input  logic              mclr_n,
  input  logic              mclr_en,
  input  logic              wdt_to,
  input  logic              sleep_i,
  input  logic              sw_rst,
  input  logic              stk_ovf,
  input  logic              stk_unf,
  input  logic              pwrt_en,
  input  logic              ost_en,
  output logic              chip_rst,
  output logic              wake,
  output logic              to_bit,
  output logic              pd_bit,
  output logic [NCAUSE-1:0] cause
);
  localparam cause_t POR_CAUSE = cause_t'(1) << C_POR;

  // ---------------- resets for both domains ----------------
  logic rst_lf_n, rst_osc_n;
  rst_sync u_rs_lf  (.clk(clk_lf),  .arst(por_det), .rst_n(rst_lf_n));
  rst_sync u_rs_osc (.clk(clk_osc), .arst(por_det), .rst_n(rst_osc_n));

  // ---------------- asynchronous inputs ----------------
  logic [1:0] async_s;
  bit_sync #(.W(2), .INIT(2'b10)) u_in_sync (
    .clk(clk_lf), .rst_n(rst_lf_n), .d({mclr_n, bor_det}), .q(async_s));
  logic pin_high_s, bor_s;
  assign pin_high_s = async_s[1];
  assign bor_s      = async_s[0];

  logic ext_act;
  pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk_lf), .rst_n(rst_lf_n), .en_i(mclr_en),
    .pin_low_i(!pin_high_s), .active_o(ext_act));

  // ---------------- power-up timer (low-frequency domain) ----------------
  logic pwrt_done, pwrt_ok;
  seq_timer #(.CNT_W(PWRT_W)) u_pwrt (
    .clk(clk_lf), .rst_n(rst_lf_n), .clr_i(bor_s),
    .start_i(1'b1), .done_o(pwrt_done));
  assign pwrt_ok = !pwrt_en || pwrt_done;

  // ---------------- start-up timer (oscillator domain) ----------------
  logic ost_done_osc, ost_done_s, ost_low_seen, tmr_clr;
  logic [1:0] to_osc;

  // Clear stays asserted until the start-up flag has been seen low in this
  // domain, so a stale completion never crosses back after a brown-out.
  always_ff @(posedge clk_lf or negedge rst_lf_n) begin
    if (!rst_lf_n)        ost_low_seen <= 1'b0;
    else if (bor_s)       ost_low_seen <= 1'b0;
    else if (!ost_done_s) ost_low_seen <= 1'b1;
  end
  assign tmr_clr = bor_s || !ost_low_seen;

  bit_sync #(.W(2), .INIT(2'b01)) u_to_osc (
    .clk(clk_osc), .rst_n(rst_osc_n), .d({pwrt_ok, tmr_clr}), .q(to_osc));

  seq_timer #(.CNT_W(OST_W)) u_ost (
    .clk(clk_osc), .rst_n(rst_osc_n), .clr_i(to_osc[0]),
    .start_i(to_osc[1]), .done_o(ost_done_osc));

  bit_sync #(.W(1), .INIT(1'b0)) u_to_lf (
    .clk(clk_lf), .rst_n(rst_lf_n), .d(ost_done_osc), .q(ost_done_s));

  logic ost_ok, seq_done;
  assign ost_ok   = !ost_en || (ost_low_seen && ost_done_s);
  assign seq_done = pwrt_ok && ost_ok;

  // ---------------- request decoding ----------------
  logic bor_q, ext_q;
  always_ff @(posedge clk_lf or negedge rst_lf_n) begin
    if (!rst_lf_n) begin
      bor_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      bor_q <= bor_s;
      ext_q <= ext_act;
    end
  end

  logic bor_rise, ext_rise, wdt_rst, wdt_wake, req_any;
  assign bor_rise = bor_s   && !bor_q;
  assign ext_rise = ext_act && !ext_q;
  assign wdt_rst  = wdt_to  && !sleep_i;
  assign wdt_wake = wdt_to  &&  sleep_i;
  assign req_any  = bor_s || ext_act || wdt_rst || sw_rst || stk_ovf || stk_unf;

  // Request vector in priority order, highest first.
  localparam int NREQ = NCAUSE - 1;
  logic [NREQ-1:0] req_vec;
  int unsigned     req_pos [NREQ];
  assign req_vec = {stk_unf, stk_ovf, sw_rst, wdt_rst, ext_rise, bor_rise};
  assign req_pos = '{C_BOR, C_EXT, C_WDT, C_SW, C_OVF, C_UNF};

  cause_t next_cause;
  logic   any_new;
  always_comb begin
    next_cause = '0;
    any_new    = 1'b0;
    for (int k = 0; k < NREQ; k++) begin
      if (req_vec[k] && !any_new) begin
        next_cause[req_pos[k]] = 1'b1;
        any_new                = 1'b1;
      end
    end
  end

  // ---------------- reset latch, cause, status ----------------
  cause_t cause_q;
  logic   rst_q, wake_q, to_q, pd_q;

  always_ff @(posedge clk_lf or negedge rst_lf_n) begin
    if (!rst_lf_n) begin
      rst_q   <= 1'b1;
      cause_q <= POR_CAUSE;
      wake_q  <= 1'b0;
      to_q    <= 1'b1;
      pd_q    <= 1'b1;
    end else begin
      if (req_any)       rst_q <= 1'b1;
      else if (seq_done) rst_q <= 1'b0;
      if (any_new)       cause_q <= next_cause;
      wake_q <= wdt_wake;
      if (wdt_wake) begin
        to_q <= 1'b0;
        pd_q <= 1'b0;
      end else begin
        if (wdt_rst)              to_q <= 1'b0;
        if (ext_rise && sleep_i)  pd_q <= 1'b0;
      end
    end
  end

  assign chip_rst = rst_q;
  assign cause    = cause_q;
  assign wake     = wake_q;
  assign to_bit   = to_q;
  assign pd_bit   = pd_q;

  p_release_after_timer_r2: assert property (@(posedge clk_lf) disable iff (!rst_lf_n)
    $fell(chip_rst) |-> $past(pwrt_ok));
  p_release_after_ost_r3: assert property (@(posedge clk_lf) disable iff (!rst_lf_n)
    ($fell(chip_rst) && $past(ost_en)) |-> $past(ost_done_s));
  p_cause_onehot_r10: assert property (@(posedge clk_lf) disable iff (!rst_lf_n)
    $countones(cause) == 1);
  p_wake_status_r8: assert property (@(posedge clk_lf) disable iff (!rst_lf_n)
    wake |-> (!to_bit && !pd_bit));
  p_pd_fall_sleep_r9: assert property (@(posedge clk_lf) disable iff (!rst_lf_n)
    $fell(pd_bit) |-> $past(sleep_i));
  p_bor_holds_r11: assert property (@(posedge clk_lf) disable iff (!rst_lf_n)
    bor_s |=> chip_rst);
endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
  logic clk_lf = 1'b0, clk_osc = 1'b0;
  always #10 clk_lf  = ~clk_lf;
  always #5  clk_osc = ~clk_osc;

  logic por_det = 1'b1, bor_det = 1'b0, mclr_n = 1'b1, mclr_en = 1'b0;
  logic wdt_to = 1'b0, sleep_i = 1'b0, sw_rst = 1'b0, stk_ovf = 1'b0, stk_unf = 1'b0;
  logic pwrt_en = 1'b1, ost_en = 1'b1;
  logic chip_rst, wake, to_bit, pd_bit;
  logic [6:0] cause;

  rst_seq_ctrl dut_i (
    .clk_lf(clk_lf), .clk_osc(clk_osc), .por_det(por_det), .bor_det(bor_det),
    .mclr_n(mclr_n), .mclr_en(mclr_en), .wdt_to(wdt_to), .sleep_i(sleep_i),
    .sw_rst(sw_rst), .stk_ovf(stk_ovf), .stk_unf(stk_unf), .pwrt_en(pwrt_en),
    .ost_en(ost_en), .chip_rst(chip_rst), .wake(wake), .to_bit(to_bit),
    .pd_bit(pd_bit), .cause(cause));

  typedef struct packed {
    logic       is_wake;
    logic [6:0] cause;
    logic       to;
    logic       pd;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, failures = 0;
  logic done_flag = 1'b0;

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic w, input logic [6:0] c, input logic t, input logic p);
    exp_t e;
    e.is_wake = w; e.cause = c; e.to = t; e.pd = p;
    exp_q.push_back(e);
  endtask

  // Monitor: each reset release or wake pulse consumes one expected item.
  logic prev_rst = 1'b1;
  always @(negedge clk_lf) begin
    if ((prev_rst && !chip_rst) || wake) begin
      exp_t got;
      got.is_wake = wake; got.cause = cause; got.to = to_bit; got.pd = pd_bit;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected event", int'(got), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(got == e, "R10 scoreboard event", int'(got), int'(e));
      end
    end
    prev_rst <= chip_rst;
  end

  task automatic strobe(input int which);
    @(negedge clk_lf);
    case (which)
      0: sw_rst = 1'b1;
      1: stk_ovf = 1'b1;
      2: stk_unf = 1'b1;
      3: wdt_to = 1'b1;
      default: begin sw_rst = 1'b1; stk_ovf = 1'b1; end
    endcase
    @(negedge clk_lf);
    sw_rst = 1'b0; stk_ovf = 1'b0; stk_unf = 1'b0; wdt_to = 1'b0;
  endtask

  task automatic wait_release(input int max, output int n);
    n = 0;
    while (chip_rst && n <= max) begin
      @(negedge clk_lf);
      n++;
    end
  endtask

  task automatic pin_low(input int cyc);
    @(negedge clk_lf);
    mclr_n = 1'b0;
    repeat (cyc) @(negedge clk_lf);
    mclr_n = 1'b1;
  endtask

  task automatic do_bor(input int lo, input int hi, input string req);
    int n;
    @(negedge clk_lf);
    bor_det = 1'b1;
    repeat (10) @(negedge clk_lf);
    check(chip_rst == 1'b1, "R11 held during brown-out", chip_rst, 1);
    bor_det = 1'b0;
    wait_release(3000, n);
    check(n >= lo && n <= hi, req, n, lo);
  endtask

  initial begin
    int n;
    // ---- first power-on with both timers ----
    repeat (3) @(negedge clk_lf);
    check(chip_rst == 1'b1, "R1 reset state chip_rst", chip_rst, 1);
    check({to_bit, pd_bit} == 2'b11, "R1 reset state status", {to_bit, pd_bit}, 3);
    check(cause == 7'b0000001, "R1 reset state cause", cause, 1);
    push(1'b0, 7'b0000001, 1'b1, 1'b1);
    por_det = 1'b0;
    repeat (2040) @(negedge clk_lf);
    check(chip_rst == 1'b1, "R2 held by power-up timer", chip_rst, 1);
    wait_release(1000, n);
    n += 2040;
    check(n >= 2560 && n <= 2700, "R3 release after both stages", n, 2560);

    // ---- synchronous strobes ----
    push(1'b0, 7'b0010000, 1'b1, 1'b1);
    strobe(0);
    check(chip_rst == 1'b1, "R6 sw reset one cycle", chip_rst, 1);
    @(negedge clk_lf);
    check(chip_rst == 1'b0, "R6 sw reset released", chip_rst, 0);
    push(1'b0, 7'b0100000, 1'b1, 1'b1);
    strobe(1);
    repeat (3) @(negedge clk_lf);
    push(1'b0, 7'b1000000, 1'b1, 1'b1);
    strobe(2);
    repeat (3) @(negedge clk_lf);
    push(1'b0, 7'b0010000, 1'b1, 1'b1);   // R10 priority: software over overflow
    strobe(4);
    repeat (3) @(negedge clk_lf);

    // ---- watchdog during sleep: wake, no reset (R8) ----
    sleep_i = 1'b1;
    push(1'b1, 7'b0010000, 1'b0, 1'b0);
    strobe(3);
    repeat (5) @(negedge clk_lf);
    check(chip_rst == 1'b0, "R8 no reset on wake", chip_rst, 0);
    check(cause == 7'b0010000, "R8 cause unchanged", cause, 16);
    sleep_i = 1'b0;

    // ---- brown-out variants (R11, R2, R3, R4) ----
    pwrt_en = 1'b1; ost_en = 1'b0;
    push(1'b0, 7'b0000010, 1'b0, 1'b0);
    do_bor(2048, 2100, "R2 power-up stage only");
    pwrt_en = 1'b0; ost_en = 1'b1;
    push(1'b0, 7'b0000010, 1'b0, 1'b0);
    do_bor(512, 700, "R3 start-up stage only");
    pwrt_en = 1'b0; ost_en = 1'b0;
    push(1'b0, 7'b0000010, 1'b0, 1'b0);
    do_bor(0, 10, "R4 both stages disabled");
    check({to_bit, pd_bit} == 2'b00, "R9 brown-out keeps status", {to_bit, pd_bit}, 0);

    // ---- second power-on, fast sequence ----
    @(negedge clk_lf);
    por_det = 1'b1;
    push(1'b0, 7'b0000001, 1'b1, 1'b1);
    repeat (4) @(negedge clk_lf);
    por_det = 1'b0;
    wait_release(50, n);
    check(chip_rst == 1'b0, "R4 power-on with stages off", chip_rst, 0);

    // ---- external pin (R5, R9) ----
    mclr_en = 1'b0;
    pin_low(20);
    repeat (6) @(negedge clk_lf);
    check(chip_rst == 1'b0, "R5 pin ignored when disabled", chip_rst, 0);
    mclr_en = 1'b1;
    pin_low(3);
    repeat (8) @(negedge clk_lf);
    check(chip_rst == 1'b0, "R5 short pulse ignored", chip_rst, 0);
    check(cause == 7'b0000001, "R5 cause after short pulse", cause, 1);
    push(1'b0, 7'b0000100, 1'b1, 1'b1);
    @(negedge clk_lf);
    mclr_n = 1'b0;
    repeat (20) @(negedge clk_lf);
    check(chip_rst == 1'b1, "R5 held while pin low", chip_rst, 1);
    mclr_n = 1'b1;
    wait_release(20, n);
    check({to_bit, pd_bit} == 2'b11, "R9 awake pin keeps status", {to_bit, pd_bit}, 3);

    // ---- watchdog reset awake (R7) ----
    push(1'b0, 7'b0001000, 1'b0, 1'b1);
    strobe(3);
    check(chip_rst == 1'b1, "R7 watchdog resets", chip_rst, 1);
    repeat (3) @(negedge clk_lf);

    // ---- pin reset during sleep (R9) ----
    sleep_i = 1'b1;
    push(1'b0, 7'b0000100, 1'b0, 1'b0);
    pin_low(15);
    wait_release(20, n);
    repeat (2) @(negedge clk_lf);
    check(pd_bit == 1'b0 && to_bit == 1'b0, "R9 sleep pin clears pd", {to_bit, pd_bit}, 0);
    sleep_i = 1'b0;

    repeat (5) @(negedge clk_lf);
    check(exp_q.size() == 0, "R10 all events seen", exp_q.size(), 0);
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (200000) @(posedge clk_lf);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule